// File: doc/BRIEF.md
# Single-Line Victim Write-Back Buffer

This block holds one dirty line that a cache has evicted, together with the line's physical address. It writes that line out to external memory later, so that the refill of the replacement line can use the memory bus first. The cache controller hands the victim over on a valid/ready load port before it starts the refill. While the refill runs, the controller holds a priority input high. The buffer drains the line only when that input is low. It does so as a run of word writes on a bus master port that uses valid/ready.

Once the line is in the buffer, the cache is free again and can keep serving CPU accesses while the drain is in progress. The buffer holds one line only, so it refuses a second load until the first line has been written out completely. The load port follows the usual stream rule: a transfer occurs on a rising clock edge where `ld_valid` and `ld_ready` are both high. The source must hold `ld_valid`, `ld_addr` and `ld_line` until that happens. On the bus port, `mem_ack` acts as ready. The buffer may raise `mem_wen` only while it is idle or between words. Once `mem_wen` is high, the buffer keeps it high and keeps the write address and data unchanged until it sees an acknowledge.

Top module: `victim_drain_buffer`

## Requirements
- R1: After reset, `busy`, `done` and `mem_wen` are 0, and `ld_ready` is 1.
- R2: A load transfer happens when `ld_valid` and `ld_ready` are both high at a clock edge. From the next cycle onward, `busy` is 1 and `ld_ready` is 0.
- R3: While the buffer is busy, `ld_ready` is 0 and a load request is refused. The stored line and address stay unchanged, so the later drain writes only the first line.
- R4: `mem_wen` is never raised in a cycle that follows a clock edge at which `refill_active` was high while no write was in flight. The refill therefore has priority over the start of the drain and over the start of each further word.
- R5: A drain consists of exactly 4 writes of 32 bits. The address of write k is the stored address with its low 4 bits cleared, plus 4·k. Its data is bits [32k+31:32k] of the loaded line, so word 0 is the least significant.
- R6: After `mem_wen` is raised, it stays high, and `mem_addr` and `mem_wdata` stay unchanged, until the clock edge at which `mem_ack` is high.
- R7: Whenever `mem_wen` is 0, `mem_addr` and `mem_wdata` are driven to zero.
- R8: `done` is high for exactly the one cycle that follows the acknowledge of the fourth write. In that same cycle `busy` is 0 and `ld_ready` is 1.
- R9: If `refill_active` rises during a drain, the write already in flight completes. The next word is not issued until `refill_active` has fallen, and the drain then resumes at the next address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| ld_valid | input | 1 | Victim line offered by the cache controller |
| ld_ready | output | 1 | Buffer empty and able to accept a line |
| ld_addr | input | 32 | Physical address of the victim line |
| ld_line | input | 128 | Victim line data, word 0 in the low bits |
| refill_active | input | 1 | Refill currently owns the bus; defer drain |
| mem_wen | output | 1 | Bus write request (valid) |
| mem_addr | output | 32 | Bus write address, zero when idle |
| mem_wdata | output | 32 | Bus write data, zero when idle |
| mem_ack | input | 1 | Memory accepts the current write (ready) |
| busy | output | 1 | A line is held and not yet fully written |
| done | output | 1 | One-cycle pulse after the last write is acknowledged |

## Verification
The assertions check on every cycle that the write request, address and data stay steady until acknowledged, and that the idle bus reads zero. They also check that no write starts while a refill holds priority, that a refused load leaves the stored line alone, and that `done` follows only a final acknowledge. The word order, the aligned address sequence, the data carried by each word and the pause-and-resume behaviour around a refill can only be shown by the bench's scenarios. Those scenarios compare every bus write with the line that was loaded.

// File: rtl/vdb_pkg.sv
package vdb_pkg;
  typedef enum logic [1:0] {
    DR_IDLE  = 2'd0,
    DR_HOLD  = 2'd1,
    DR_WRITE = 2'd2
  } drain_state_t;
endpackage

// File: rtl/vdb_line_store.sv
module vdb_line_store #(
  parameter int ADDR_W = 32,
  parameter int WORD_W = 32,
  parameter int WORDS  = 4,
  localparam int IDX_W  = (WORDS > 1) ? $clog2(WORDS) : 1,
  localparam int BYTE_W = $clog2(WORD_W / 8),
  localparam int OFF_W  = IDX_W + BYTE_W
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    capture,
  input  logic                    hold_busy,
  input  logic [ADDR_W-1:0]       in_addr,
  input  logic [WORDS*WORD_W-1:0] in_line,
  input  logic [IDX_W-1:0]        sel,
  input  logic                    drive,
  output logic [ADDR_W-1:0]       out_addr,
  output logic [WORD_W-1:0]       out_word
);
  logic [WORD_W-1:0]       slot_q [WORDS];
  logic [ADDR_W-OFF_W-1:0] tag_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tag_q <= '0;
    end else if (capture) begin
      tag_q <= in_addr[ADDR_W-1:OFF_W];
    end
  end

  for (genvar g = 0; g < WORDS; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n) slot_q[g] <= '0;
      else if (capture) slot_q[g] <= in_line[g*WORD_W +: WORD_W];
    end
  end

  always_comb begin
    if (drive) begin
      out_addr = {tag_q, sel, {BYTE_W{1'b0}}};
      out_word = slot_q[sel];
    end else begin
      out_addr = '0;
      out_word = '0;
    end
  end

  // R3
  stored_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_busy && !capture) |=> $stable(tag_q) && $stable(slot_q[0]));
endmodule

// File: rtl/vdb_drain_fsm.sv
module vdb_drain_fsm
  import vdb_pkg::*;
#(
  parameter int WORDS = 4,
  localparam int IDX_W = (WORDS > 1) ? $clog2(WORDS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ld_valid,
  input  logic             refill_active,
  input  logic             mem_ack,
  output logic             ld_ready,
  output logic             capture,
  output logic             mem_wen,
  output logic [IDX_W-1:0] word_idx,
  output logic             busy,
  output logic             done
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(WORDS - 1);

  drain_state_t st_q, st_d;
  logic [IDX_W-1:0] idx_q;
  logic done_q;
  logic last_ack;

  assign ld_ready = (st_q == DR_IDLE);
  assign capture  = ld_valid && ld_ready;
  assign mem_wen  = (st_q == DR_WRITE);
  assign busy     = (st_q != DR_IDLE);
  assign word_idx = idx_q;
  assign done     = done_q;
  assign last_ack = mem_wen && mem_ack && (idx_q == LAST_IDX);

  always_comb begin
    st_d = st_q;
    case (st_q)
      DR_IDLE:  if (capture) st_d = DR_HOLD;
      DR_HOLD:  if (!refill_active) st_d = DR_WRITE;
      DR_WRITE: if (mem_ack) st_d = (idx_q == LAST_IDX) ? DR_IDLE : DR_HOLD;
      default:  st_d = DR_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= DR_IDLE;
      idx_q  <= '0;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      done_q <= last_ack;
      if (capture) idx_q <= '0;
      else if (mem_wen && mem_ack) idx_q <= idx_q + 1'b1;
    end
  end

  // R4
  refill_defer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (refill_active && !mem_wen) |=> !mem_wen);

  // R8
  done_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> ($past(mem_wen && mem_ack) && !busy));

  // R2
  load_takes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    capture |=> (busy && !ld_ready));
endmodule

// File: rtl/victim_drain_buffer.sv
module victim_drain_buffer #(
  parameter int ADDR_W = 32,
  parameter int WORD_W = 32,
  parameter int WORDS  = 4,
  localparam int IDX_W = (WORDS > 1) ? $clog2(WORDS) : 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    ld_valid,
  output logic                    ld_ready,
  input  logic [ADDR_W-1:0]       ld_addr,
  input  logic [WORDS*WORD_W-1:0] ld_line,
  input  logic                    refill_active,
  output logic                    mem_wen,
  output logic [ADDR_W-1:0]       mem_addr,
  output logic [WORD_W-1:0]       mem_wdata,
  input  logic                    mem_ack,
  output logic                    busy,
  output logic                    done
);
  logic             cap;
  logic [IDX_W-1:0] idx;

  vdb_drain_fsm #(.WORDS(WORDS)) u_fsm (
    .clk(clk), .rst_n(rst_n), .ld_valid(ld_valid),
    .refill_active(refill_active), .mem_ack(mem_ack),
    .ld_ready(ld_ready), .capture(cap), .mem_wen(mem_wen),
    .word_idx(idx), .busy(busy), .done(done)
  );

  vdb_line_store #(.ADDR_W(ADDR_W), .WORD_W(WORD_W), .WORDS(WORDS)) u_store (
    .clk(clk), .rst_n(rst_n), .capture(cap), .hold_busy(busy),
    .in_addr(ld_addr), .in_line(ld_line), .sel(idx), .drive(mem_wen),
    .out_addr(mem_addr), .out_word(mem_wdata)
  );

  // R6
  bus_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wen && !mem_ack) |=> (mem_wen && $stable(mem_addr) && $stable(mem_wdata)));

  // R7
  idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_wen |-> (mem_addr == '0 && mem_wdata == '0));
endmodule

// File: tb/victim_drain_buffer_bench.sv
module victim_drain_buffer_bench;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ld_valid = 1'b0;
  logic ld_ready;
  logic [31:0] ld_addr = '0;
  logic [127:0] ld_line = '0;
  logic refill_active = 1'b0;
  logic mem_wen;
  logic [31:0] mem_addr;
  logic [31:0] mem_wdata;
  logic mem_ack = 1'b0;
  logic busy;
  logic done;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  victim_drain_buffer u_victim_drain_buffer (
    .clk(clk), .rst_n(rst_n), .ld_valid(ld_valid), .ld_ready(ld_ready),
    .ld_addr(ld_addr), .ld_line(ld_line), .refill_active(refill_active),
    .mem_wen(mem_wen), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .busy(busy), .done(done)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [127:0] mk_line(input logic [7:0] seed);
    logic [127:0] l;
    for (int i = 0; i < 4; i++) l[i*32 +: 32] = {seed, 8'(i), 16'hA5C3 ^ {seed, seed}};
    return l;
  endfunction

  task automatic load_line(input logic [31:0] a, input logic [127:0] l);
    @(negedge clk);
    ld_valid = 1'b1; ld_addr = a; ld_line = l;
    check("R2 ready before load", {31'd0, ld_ready}, 32'd1);
    @(negedge clk);
    ld_valid = 1'b0;
    check("R2 busy after load", {31'd0, busy}, 32'd1);
    check("R2 ready low after load", {31'd0, ld_ready}, 32'd0);
  endtask

  // wait for a write, hold ack off for 'stall' cycles, then acknowledge and compare
  task automatic serve_word(input int stall, input logic [31:0] ea, input logic [31:0] ed, input bit last);
    int n = 0;
    logic [31:0] a0, d0;
    while (!mem_wen && n < 60) begin @(negedge clk); n++; end
    check("R5 write issued", {31'd0, mem_wen}, 32'd1);
    a0 = mem_addr; d0 = mem_wdata;
    check("R5 address", a0, ea);
    check("R5 data", d0, ed);
    for (int s = 0; s < stall; s++) begin
      @(negedge clk);
      check("R6 wen held", {31'd0, mem_wen}, 32'd1);
      check("R6 addr held", mem_addr, a0);
      check("R6 data held", mem_wdata, d0);
    end
    mem_ack = 1'b1;
    @(negedge clk);
    mem_ack = 1'b0;
    check("R7 idle addr zero", mem_addr, 32'd0);
    check("R7 idle data zero", mem_wdata, 32'd0);
    if (last) begin
      check("R8 done pulse", {31'd0, done}, 32'd1);
      check("R8 busy cleared", {31'd0, busy}, 32'd0);
      check("R8 ready back", {31'd0, ld_ready}, 32'd1);
      @(negedge clk);
      check("R8 done one cycle", {31'd0, done}, 32'd0);
    end else begin
      check("R8 no early done", {31'd0, done}, 32'd0);
    end
  endtask

  task automatic drain_all(input logic [31:0] a, input logic [127:0] l, input int stall);
    for (int k = 0; k < 4; k++)
      serve_word(stall, {a[31:4], 4'h0} + 32'(4*k), l[k*32 +: 32], k == 3);
  endtask

  task automatic t_reset();
    check("R1 busy", {31'd0, busy}, 32'd0);
    check("R1 done", {31'd0, done}, 32'd0);
    check("R1 wen", {31'd0, mem_wen}, 32'd0);
    check("R1 ready", {31'd0, ld_ready}, 32'd1);
  endtask

  task automatic t_basic();
    logic [127:0] l = mk_line(8'h11);
    load_line(32'h0000_1234, l);
    drain_all(32'h0000_1234, l, 0);
  endtask

  task automatic t_refill_defer();
    logic [127:0] l = mk_line(8'h22);
    refill_active = 1'b1;
    load_line(32'h8000_00F8, l);
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      check("R4 no write during refill", {31'd0, mem_wen}, 32'd0);
    end
    refill_active = 1'b0;
    drain_all(32'h8000_00F8, l, 1);
  endtask

  task automatic t_refuse();
    logic [127:0] l1 = mk_line(8'h33);
    logic [127:0] l2 = mk_line(8'h44);
    refill_active = 1'b1;
    load_line(32'h0040_0020, l1);
    @(negedge clk);
    ld_valid = 1'b1; ld_addr = 32'h0FF0_0000; ld_line = l2;
    check("R3 refused while busy", {31'd0, ld_ready}, 32'd0);
    @(negedge clk);
    @(negedge clk);
    ld_valid = 1'b0;
    refill_active = 1'b0;
    drain_all(32'h0040_0020, l1, 0);
  endtask

  task automatic t_stall();
    logic [127:0] l = mk_line(8'h55);
    load_line(32'hFFFF_FFF0, l);
    drain_all(32'hFFFF_FFF0, l, 3);
  endtask

  task automatic t_refill_midway();
    logic [127:0] l = mk_line(8'h66);
    load_line(32'h1234_567C, l);
    serve_word(1, 32'h1234_5670, l[31:0], 1'b0);
    refill_active = 1'b1;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      check("R9 paused during refill", {31'd0, mem_wen}, 32'd0);
      check("R9 still busy", {31'd0, busy}, 32'd1);
    end
    refill_active = 1'b0;
    for (int k = 1; k < 4; k++)
      serve_word(0, 32'h1234_5670 + 32'(4*k), l[k*32 +: 32], k == 3);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_refill_defer();
    t_refuse();
    t_stall();
    t_refill_midway();
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule